// File: doc/BRIEF.md
# Multi-Function Register Access Sequencer

This block sits between a host-side transfer engine and the internal register space of a multi-function I/O device. The host hands it one request at a time: a function number, a 17-bit byte address, a direction, an addressing mode and a length. The sequencer then performs one byte-wide register cycle per byte of the transfer. It streams write bytes in from a valid/ready port and read bytes out on another valid/ready port.

Functions 1 to 7 are I/O functions, each with its own 2^17-byte space. Function 0 selects a separate common control space. Each byte's register cycle is guarded by an access-time watchdog sized to one second at the configured clock. While a write byte is outstanding the block drives `busy`. While a read byte is still being fetched it drives `readHold`, which holds off the start of read data. A transfer either repeats one address, which suits draining or filling a FIFO port, or walks upward through a buffer region. Its length is counted in bytes or in blocks of a configurable size.

Top module: `fn_reg_sequencer`

## Requirements
- R1: After reset the block is idle. `reqReady` is 1. `rbReq`, `rbSel`, `busy`, `readHold`, `wrReady`, `rdValid`, `xferDone`, `timeoutFlag` and `wrapFlag` are all 0.
- R2: During every register cycle, `rbSel` is one-hot with bit n set for function number n, where bit 0 is the common control space. `rbSel` is all zero when no cycle is outstanding.
- R3: A transfer performs exactly as many register cycles as its length. In byte mode (`reqBlockMode`=0) the length is `reqCount` bytes, and a count of 0 means 512. In block mode the length is `reqCount` blocks times `blkSize` bytes, and a value of 0 in either field means 512.
- R4: In fixed mode (`reqIncr`=0) every register cycle of the transfer uses the request address.
- R5: In incrementing mode (`reqIncr`=1) byte k of the transfer uses the request address plus k, taken modulo 2^17.
- R6: When an incrementing transfer moves on from address 0x1FFFF to a further byte, it continues at 0x00000 and sets the sticky `wrapFlag`. A transfer whose last byte is at 0x1FFFF leaves the flag at 0.
- R7: In a write, `wrReady` is 1 only while the block waits for the next host byte. `busy` is 1 exactly while that byte's register cycle is outstanding. `rbWdata` equals the byte taken from the host.
- R8: In a read, `readHold` is 1 while the byte's register cycle is outstanding. `rdValid` rises only in the cycle after `rbAck`, and `rdData` carries the `rbRdata` value sampled with that acknowledge.
- R9: Once raised, `rbReq` stays high with a stable address and select until the clock edge at which `rbAck` is 1, unless the watchdog aborts the cycle.
- R10: A register cycle may last at most CLK_HZ clock cycles, with the acknowledge arriving in the last of them at the latest. Otherwise the cycle is dropped, the transfer ends, and the sticky `timeoutFlag` is set.
- R11: `xferDone` is a one-cycle pulse in the cycle after the final byte's handshake, or after a watchdog abort. `reqReady` is 1 in that cycle.
- R12: A request is taken only while `reqReady` is 1. Taking a request clears `timeoutFlag` and `wrapFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken (idle) |
| reqFunc | input | 3 | Function number, 0 = common control space |
| reqAddr | input | 17 | Start byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIncr | input | 1 | 1 = incrementing address, 0 = fixed address |
| reqBlockMode | input | 1 | 1 = length in blocks, 0 = length in bytes |
| reqCount | input | 9 | Byte or block count, 0 = 512 |
| blkSize | input | 9 | Block size in bytes, 0 = 512 |
| wrValid | input | 1 | Host write byte valid |
| wrReady | output | 1 | Block takes a write byte |
| wrData | input | 8 | Host write byte |
| rdValid | output | 1 | Read byte valid |
| rdReady | input | 1 | Host takes the read byte |
| rdData | output | 8 | Read byte |
| busy | output | 1 | Write byte register cycle in progress |
| readHold | output | 1 | Read data start held off |
| rbReq | output | 1 | Register cycle request |
| rbWrite | output | 1 | Register cycle direction |
| rbSel | output | 8 | One-hot function select |
| rbAddr | output | 17 | Register byte address |
| rbWdata | output | 8 | Register write byte |
| rbRdata | input | 8 | Register read byte |
| rbAck | input | 1 | Register cycle complete |
| xferDone | output | 1 | Transfer finished pulse |
| timeoutFlag | output | 1 | Sticky watchdog abort status |
| wrapFlag | output | 1 | Sticky address wrap status |

## Verification
The main function is driven with single-byte writes, fixed-address writes and reads, incrementing reads and writes, and block-mode reads. These cases separate repeated-address behaviour from address stepping, and byte-count lengths from block products. A 0x1FFFF start that crosses the top of the space is paired with one that ends exactly on it, to separate a true wrap from a last-byte hit. Zero counts in both fields, together with a function-0 request, probe the 512 encoding and the common-space select. Acknowledge delays of zero, several cycles, exactly the watchdog limit, and never, separate normal hold-off and busy from an abort.

// File: rtl/fn_seq_pkg.sv
package fn_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_WAIT,
    S_WR_ACC,
    S_RD_ACC,
    S_RD_PUSH
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // take the request fields
    logic latchWr;    // take a host write byte
    logic captureRd;  // take the register read byte
    logic advance;    // byte done: count down, step address
    logic wdRun;      // watchdog keeps counting
    logic abort;      // watchdog expired
    logic finish;     // transfer over
  } ctrl_strobe_t;

endpackage

// File: rtl/fn_seq_ctrl.sv
module fn_seq_ctrl
  import fn_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         wrValid,
  input  logic         rdReady,
  input  logic         rbAck,
  input  logic         lastByte,
  input  logic         wdExpired,
  output logic         reqReady,
  output logic         wrReady,
  output logic         rdValid,
  output logic         rbReq,
  output logic         busy,
  output logic         readHold,
  output ctrl_strobe_t strobe
);

  seq_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          nextState   = reqWrite ? S_WR_WAIT : S_RD_ACC;
        end
      end
      S_WR_WAIT: begin
        if (wrValid) begin
          strobe.latchWr = 1'b1;
          nextState      = S_WR_ACC;
        end
      end
      S_WR_ACC: begin
        if (rbAck) begin
          strobe.advance = 1'b1;
          strobe.finish  = lastByte;
          nextState      = lastByte ? S_IDLE : S_WR_WAIT;
        end else if (wdExpired) begin
          strobe.abort  = 1'b1;
          strobe.finish = 1'b1;
          nextState     = S_IDLE;
        end else begin
          strobe.wdRun = 1'b1;
        end
      end
      S_RD_ACC: begin
        if (rbAck) begin
          strobe.captureRd = 1'b1;
          nextState        = S_RD_PUSH;
        end else if (wdExpired) begin
          strobe.abort  = 1'b1;
          strobe.finish = 1'b1;
          nextState     = S_IDLE;
        end else begin
          strobe.wdRun = 1'b1;
        end
      end
      S_RD_PUSH: begin
        if (rdReady) begin
          strobe.advance = 1'b1;
          strobe.finish  = lastByte;
          nextState      = lastByte ? S_IDLE : S_RD_ACC;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign wrReady  = (state == S_WR_WAIT);
  assign rdValid  = (state == S_RD_PUSH);
  assign busy     = (state == S_WR_ACC);
  assign readHold = (state == S_RD_ACC);
  assign rbReq    = busy || readHold;

  // R9: an outstanding cycle is held until acknowledged or aborted
  a_r9_req_held : assert property (@(posedge clk) disable iff (!rstN)
    (rbReq && !rbAck && !wdExpired) |=> rbReq);

  // R8: read data is offered only after an acknowledge
  a_r8_data_after_ack : assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(rbAck));

  // R12: a taken request starts a data phase at once
  a_r12_accept_starts : assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (wrReady || rbReq));

endmodule

// File: rtl/fn_seq_dpath.sv
module fn_seq_dpath
  import fn_seq_pkg::*;
#(
  parameter int NUM_FN = 8,
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 9,
  parameter int BLK_W  = 9,
  parameter int LIMIT  = 250_000_000,
  localparam int FN_W  = $clog2(NUM_FN),
  localparam int LEN_W = CNT_W + BLK_W + 2,
  localparam int WD_W  = $clog2(LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic              rbReq,
  input  logic [FN_W-1:0]   reqFunc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqIncr,
  input  logic              reqBlockMode,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [BLK_W-1:0]  blkSize,
  input  logic [7:0]        wrData,
  input  logic [7:0]        rbRdata,
  output logic [7:0]        rdData,
  output logic              rbWrite,
  output logic [NUM_FN-1:0] rbSel,
  output logic [ADDR_W-1:0] rbAddr,
  output logic [7:0]        rbWdata,
  output logic              lastByte,
  output logic              wdExpired,
  output logic              xferDone,
  output logic              timeoutFlag,
  output logic              wrapFlag
);

  localparam int CNT_MAX = 1 << CNT_W;
  localparam int BLK_MAX = 1 << BLK_W;

  logic [FN_W-1:0]   fnQ;
  logic [ADDR_W-1:0] addrQ;
  logic              incrQ, writeQ;
  logic [LEN_W-1:0]  remQ;
  logic [7:0]        wrByteQ, rdByteQ;
  logic [WD_W-1:0]   wdCntQ;
  logic              timeoutQ, wrapQ, doneQ;

  // transfer length in bytes, zero fields standing for the maximum
  logic [LEN_W-1:0] lenUnits, lenSize, lenTotal;
  always_comb begin
    lenUnits = (reqCount == '0) ? LEN_W'(CNT_MAX) : LEN_W'(reqCount);
    if (!reqBlockMode)        lenSize = LEN_W'(1);
    else if (blkSize == '0)   lenSize = LEN_W'(BLK_MAX);
    else                      lenSize = LEN_W'(blkSize);
    lenTotal = lenUnits * lenSize;
  end

  logic addrTop;
  assign addrTop = (addrQ == {ADDR_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fnQ      <= '0;
      addrQ    <= '0;
      incrQ    <= 1'b0;
      writeQ   <= 1'b0;
      remQ     <= '0;
      wrByteQ  <= '0;
      rdByteQ  <= '0;
      timeoutQ <= 1'b0;
      wrapQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= strobe.finish;
      if (strobe.load) begin
        fnQ      <= reqFunc;
        addrQ    <= reqAddr;
        incrQ    <= reqIncr;
        writeQ   <= reqWrite;
        remQ     <= lenTotal;
        timeoutQ <= 1'b0;
        wrapQ    <= 1'b0;
      end
      if (strobe.latchWr)   wrByteQ <= wrData;
      if (strobe.captureRd) rdByteQ <= rbRdata;
      if (strobe.advance) begin
        remQ <= remQ - 1'b1;
        if (incrQ) begin
          addrQ <= addrQ + 1'b1;
          if (addrTop && !lastByte) wrapQ <= 1'b1;
        end
      end
      if (strobe.abort) timeoutQ <= 1'b1;
    end
  end

  // access-time watchdog, cleared whenever no cycle is waiting
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.wdRun) wdCntQ <= '0;
    else                        wdCntQ <= wdCntQ + 1'b1;
  end

  assign wdExpired = (wdCntQ == WD_W'(LIMIT - 1));
  assign lastByte  = (remQ == LEN_W'(1));

  for (genvar g = 0; g < NUM_FN; g++) begin : g_sel
    assign rbSel[g] = rbReq && (fnQ == FN_W'(g));
  end

  assign rbAddr      = addrQ;
  assign rbWrite     = writeQ;
  assign rbWdata     = wrByteQ;
  assign rdData      = rdByteQ;
  assign xferDone    = doneQ;
  assign timeoutFlag = timeoutQ;
  assign wrapFlag    = wrapQ;

  // R3: a taken request never has an empty length
  a_r3_len_nonzero : assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (remQ != '0));

  // R4: fixed mode keeps its address across bytes
  a_r4_fixed_addr : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !incrQ) |=> $stable(addrQ));

  // R5: incrementing mode steps by one byte
  a_r5_incr_addr : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && incrQ) |=> (addrQ == $past(addrQ) + 1'b1));

  // R6: the wrap flag rises only on a step past the top address
  a_r6_wrap_cause : assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrapQ) |-> $past(strobe.advance && incrQ && addrTop));

  // R10: watchdog never counts beyond its limit, and an abort is recorded
  a_r10_wd_bound : assert property (@(posedge clk) disable iff (!rstN)
    wdCntQ < WD_W'(LIMIT));
  a_r10_abort_flag : assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> timeoutQ);

  // R11: done is a single-cycle pulse
  a_r11_done_pulse : assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

endmodule

// File: rtl/fn_reg_sequencer.sv
module fn_reg_sequencer
  import fn_seq_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000,
  parameter int NUM_FN = 8,
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 9,
  parameter int BLK_W  = 9,
  localparam int FN_W  = $clog2(NUM_FN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [FN_W-1:0]   reqFunc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqIncr,
  input  logic              reqBlockMode,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [BLK_W-1:0]  blkSize,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [7:0]        wrData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              readHold,
  output logic              rbReq,
  output logic              rbWrite,
  output logic [NUM_FN-1:0] rbSel,
  output logic [ADDR_W-1:0] rbAddr,
  output logic [7:0]        rbWdata,
  input  logic [7:0]        rbRdata,
  input  logic              rbAck,
  output logic              xferDone,
  output logic              timeoutFlag,
  output logic              wrapFlag
);

  ctrl_strobe_t strobe;
  logic lastByte, wdExpired;

  fn_seq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .wrValid   (wrValid),
    .rdReady   (rdReady),
    .rbAck     (rbAck),
    .lastByte  (lastByte),
    .wdExpired (wdExpired),
    .reqReady  (reqReady),
    .wrReady   (wrReady),
    .rdValid   (rdValid),
    .rbReq     (rbReq),
    .busy      (busy),
    .readHold  (readHold),
    .strobe    (strobe)
  );

  fn_seq_dpath #(
    .NUM_FN (NUM_FN),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BLK_W  (BLK_W),
    .LIMIT  (CLK_HZ)
  ) i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .rbReq        (rbReq),
    .reqFunc      (reqFunc),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .reqIncr      (reqIncr),
    .reqBlockMode (reqBlockMode),
    .reqCount     (reqCount),
    .blkSize      (blkSize),
    .wrData       (wrData),
    .rbRdata      (rbRdata),
    .rdData       (rdData),
    .rbWrite      (rbWrite),
    .rbSel        (rbSel),
    .rbAddr       (rbAddr),
    .rbWdata      (rbWdata),
    .lastByte     (lastByte),
    .wdExpired    (wdExpired),
    .xferDone     (xferDone),
    .timeoutFlag  (timeoutFlag),
    .wrapFlag     (wrapFlag)
  );

  // R2: one function selected per cycle, none between cycles
  a_r2_sel_onehot : assert property (@(posedge clk) disable iff (!rstN)
    rbReq |-> ($countones(rbSel) == 1));
  a_r2_sel_idle : assert property (@(posedge clk) disable iff (!rstN)
    !rbReq |-> (rbSel == '0));

  // R7: busy only during an outstanding write cycle, host port closed
  a_r7_busy_write : assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (rbReq && rbWrite && !wrReady));

  // R8: read hold-off only during an outstanding read cycle
  a_r8_hold_read : assert property (@(posedge clk) disable iff (!rstN)
    readHold |-> (rbReq && !rbWrite && !rdValid));

endmodule

// File: tb/test_fn_reg_sequencer.sv
`timescale 1ns/1ps
module test_fn_reg_sequencer;

  localparam int TB_LIMIT = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        reqValid = 0, reqWrite = 0, reqIncr = 0, reqBlockMode = 0;
  logic [2:0]  reqFunc = '0;
  logic [16:0] reqAddr = '0;
  logic [8:0]  reqCount = '0, blkSize = '0;
  logic        wrValid = 0, rdReady = 1;
  logic [7:0]  wrData = '0, rbRdata = '0;
  logic        rbAck = 0;
  logic        reqReady, wrReady, rdValid, busy, readHold, rbReq, rbWrite;
  logic        xferDone, timeoutFlag, wrapFlag;
  logic [7:0]  rdData, rbWdata, rbSel;
  logic [16:0] rbAddr;

  fn_reg_sequencer #(.CLK_HZ(TB_LIMIT)) i_fn_reg_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqFunc(reqFunc), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqIncr(reqIncr),
    .reqBlockMode(reqBlockMode), .reqCount(reqCount), .blkSize(blkSize),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .busy(busy), .readHold(readHold), .rbReq(rbReq), .rbWrite(rbWrite),
    .rbSel(rbSel), .rbAddr(rbAddr), .rbWdata(rbWdata), .rbRdata(rbRdata),
    .rbAck(rbAck), .xferDone(xferDone), .timeoutFlag(timeoutFlag), .wrapFlag(wrapFlag)
  );

  int nChk = 0, nBad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // transfer context seen by the register model
  logic [2:0]  curFn = '0;
  logic [16:0] curAddr = '0;
  logic        curIncr = 0, curWr = 0;
  logic [7:0]  curSeed = '0;
  int          curDly = 0, accIdx = 0, waitCnt = 0;
  bit          stall = 0;

  function automatic logic [16:0] expAddr(input int idx);
    logic [16:0] a;
    a = curAddr + 17'(idx);
    return curIncr ? a : curAddr;
  endfunction

  function automatic logic [7:0] rdPat(input logic [16:0] a, input logic [2:0] f);
    return a[7:0] ^ a[15:8] ^ {f, 5'd0} ^ {7'd0, a[16]};
  endfunction

  // register space model, decides acknowledges at the falling edge
  always @(negedge clk) begin
    if (rbAck) begin
      rbAck = 1'b0;
      waitCnt = 0;
    end else if (rstN && rbReq) begin
      chk(waitCnt == 0 ? (curIncr ? "R5 addr" : "R4 addr") : "R9 addr held",
          32'(rbAddr), 32'(expAddr(accIdx)));
      chk("R2 select", 32'(rbSel), 32'(8'b1 << curFn));
      if (curWr) begin
        chk("R7 busy", 32'(busy), 1);
        chk("R7 wrReady closed", 32'(wrReady), 0);
        chk("R7 wdata", 32'(rbWdata), 32'(curSeed ^ 8'(accIdx)));
      end else begin
        chk("R8 readHold", 32'(readHold), 1);
      end
      if (!stall && waitCnt == curDly) begin
        rbAck = 1'b1;
        rbRdata = rdPat(rbAddr, curFn);
        accIdx++;
      end else begin
        waitCnt++;
      end
    end else begin
      waitCnt = 0;
    end
  end

  typedef struct packed {
    logic [2:0]  fn;
    logic [16:0] addr;
    logic        wr;
    logic        inc;
    logic        blk;
    logic [8:0]  cnt;
    logic [8:0]  bsz;
    logic [3:0]  dly;
    logic [19:0] len;
    logic        wrap;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 17'h00010, 1'b1, 1'b1, 1'b0, 9'd1, 9'd0, 4'd0, 20'd1,   1'b0},
    '{3'd2, 17'h00100, 1'b1, 1'b0, 1'b0, 9'd5, 9'd0, 4'd2, 20'd5,   1'b0},
    '{3'd3, 17'h00200, 1'b0, 1'b1, 1'b0, 9'd6, 9'd0, 4'd1, 20'd6,   1'b0},
    '{3'd7, 17'h1FFFD, 1'b0, 1'b1, 1'b0, 9'd5, 9'd0, 4'd0, 20'd5,   1'b1},
    '{3'd0, 17'h00040, 1'b1, 1'b0, 1'b0, 9'd3, 9'd0, 4'd3, 20'd3,   1'b0},
    '{3'd4, 17'h00000, 1'b0, 1'b0, 1'b1, 9'd2, 9'd3, 4'd1, 20'd6,   1'b0},
    '{3'd5, 17'h1FFFE, 1'b1, 1'b1, 1'b0, 9'd2, 9'd0, 4'd0, 20'd2,   1'b0},
    '{3'd6, 17'h00300, 1'b1, 1'b1, 1'b0, 9'd0, 9'd0, 4'd0, 20'd512, 1'b0},
    '{3'd1, 17'h00800, 1'b0, 1'b1, 1'b1, 9'd1, 9'd0, 4'd0, 20'd512, 1'b0}
  };

  task automatic issue(input vec_t v, input int dly, input bit stl);
    int n = 0;
    @(negedge clk);
    while (!reqReady && n < 5000) begin @(negedge clk); n++; end
    curFn = v.fn; curAddr = v.addr; curIncr = v.inc; curWr = v.wr;
    curSeed = 8'(v.addr) ^ {v.fn, 5'h15}; curDly = dly; stall = stl; accIdx = 0;
    reqFunc = v.fn; reqAddr = v.addr; reqWrite = v.wr; reqIncr = v.inc;
    reqBlockMode = v.blk; reqCount = v.cnt; blkSize = v.bsz; reqValid = 1'b1;
    @(posedge clk); #1 reqValid = 1'b0;
  endtask

  task automatic feedByte(input logic [7:0] b);
    int n = 0;
    @(negedge clk);
    while (!wrReady && n < 5000) begin @(negedge clk); n++; end
    wrValid = 1'b1; wrData = b;
    @(posedge clk); #1 wrValid = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    int n = 0;
    seen = 0;
    while (n < 5000) begin
      @(negedge clk);
      if (xferDone) begin seen = 1; break; end
      n++;
    end
  endtask

  // run one complete transfer and check its outcome
  task automatic runXfer(input vec_t v, input int dly);
    bit seen;
    int got = 0;
    issue(v, dly, 0);
    chk("R12 flags cleared on accept", 32'({timeoutFlag, wrapFlag}), 0);
    if (v.wr) begin
      for (int i = 0; i < int'(v.len); i++) feedByte(curSeed ^ 8'(i));
      waitDone(seen);
    end else begin
      seen = 0;
      for (int n = 0; n < 20000; n++) begin
        @(negedge clk);
        if (rdValid) begin
          chk("R8 rdData", 32'(rdData), 32'(rdPat(expAddr(got), curFn)));
          got++;
        end
        if (xferDone) begin seen = 1; break; end
      end
      chk("R3 bytes delivered", 32'(got), 32'(v.len));
    end
    chk("R11 done seen", 32'(seen), 1);
    chk("R11 ready at done", 32'(reqReady), 1);
    chk("R3 register cycles", 32'(accIdx), 32'(v.len));
    chk("R6 wrap flag", 32'(wrapFlag), 32'(v.wrap));
    chk("R10 no timeout", 32'(timeoutFlag), 0);
    @(negedge clk);
    chk("R11 single pulse", 32'(xferDone), 0);
  endtask

  initial begin : main
    vec_t v;
    bit seen;
    int cnt;
    bit leak;
    repeat (3) @(negedge clk);
    chk("R1 reqReady", 32'(reqReady), 1);
    chk("R1 idle outputs",
        32'({rbReq, busy, readHold, wrReady, rdValid, xferDone, timeoutFlag, wrapFlag}), 0);
    chk("R1 select", 32'(rbSel), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 32'({reqReady, rbReq, busy, readHold}), 32'b1000);

    for (int k = 0; k < NV; k++) runXfer(VECS[k], int'(VECS[k].dly));

    // R10: acknowledge in the last permitted cycle still completes
    v = '{3'd2, 17'h00020, 1'b1, 1'b0, 1'b0, 9'd1, 9'd0, 4'd0, 20'd1, 1'b0};
    runXfer(v, TB_LIMIT - 1);

    // R10: stalled write is aborted after the limit
    v = '{3'd3, 17'h00050, 1'b1, 1'b1, 1'b0, 9'd2, 9'd0, 4'd0, 20'd2, 1'b0};
    issue(v, 0, 1);
    feedByte(curSeed);
    cnt = 0; seen = 0; leak = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (busy) cnt++;
      if (wrReady) leak = 1;
      if (xferDone) begin seen = 1; break; end
    end
    chk("R10 write busy cycles", 32'(cnt), TB_LIMIT);
    chk("R10 write abort done", 32'(seen), 1);
    chk("R10 timeout flag", 32'(timeoutFlag), 1);
    chk("R10 no further byte taken", 32'(leak), 0);
    chk("R10 request dropped", 32'(rbReq), 0);
    chk("R11 ready after abort", 32'(reqReady), 1);

    // R10: stalled read holds off, then aborts with no data
    v = '{3'd6, 17'h00070, 1'b0, 1'b0, 1'b0, 9'd3, 9'd0, 4'd0, 20'd3, 1'b0};
    issue(v, 0, 1);
    cnt = 0; seen = 0; leak = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (readHold) cnt++;
      if (rdValid) leak = 1;
      if (xferDone) begin seen = 1; break; end
    end
    chk("R10 read hold cycles", 32'(cnt), TB_LIMIT);
    chk("R10 read abort done", 32'(seen), 1);
    chk("R10 no read data", 32'(leak), 0);
    chk("R10 timeout flag read", 32'(timeoutFlag), 1);
    stall = 0;

    // R12: next request clears the sticky timeout and works normally
    v = '{3'd5, 17'h00090, 1'b0, 1'b1, 1'b0, 9'd2, 9'd0, 4'd0, 20'd2, 1'b0};
    runXfer(v, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule